// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block tracks every decoded instruction between the point where it leaves decode and the point where it updates architectural state. Instructions enter at the tail in program order and receive a slot tag. Execution units may finish them in any order and report completion against that tag. The buffer retires at most one instruction per cycle, always the oldest one, and only once that instruction has finished. On retirement it presents the architectural destination, the physical register that destination was mapped to before, so that it can be recycled, and the instruction's PC.

Speculation is undone in two ways. A branch that turns out mispredicted names its own tag. Every entry younger than that branch is discarded by pulling the tail back to the slot just after it, and a redirect to the corrected PC is raised. Several branches may be pending at once and may resolve in any order. An exception is recorded in the entry when it completes, and it is acted on only when that entry becomes the oldest one. The whole buffer is then emptied, and a redirect to a fixed handler address is raised.

Top module: `reorder_buffer`

## Requirements
- R1: After reset the buffer is empty: `commit_valid` and `redirect_valid` are 0, `alloc_ready` is 1 and `alloc_tag` is 0.
- R2: Each accepted allocation takes the slot given by `alloc_tag`. Consecutive allocations get consecutive tags, and the tag wraps from DEPTH-1 to 0.
- R3: An entry retires only when it is the oldest entry and has been marked done. Retirements happen one per cycle, in allocation order, whatever order the completions arrived in. A retirement presents the entry's destination, prior mapping and PC on the `commit_*` outputs while `commit_valid` is 1.
- R4: When DEPTH entries are held, `alloc_ready` is 0 and an asserted `alloc_valid` adds no entry.
- R5: A mispredict on a live tag discards all younger entries. The next allocation receives that tag plus one (mod DEPTH). `redirect_valid` is 1 in the cycle after, with `redirect_pc` equal to `mp_target`. An allocation offered in the same cycle as the mispredict is dropped.
- R6: Mispredicts may arrive youngest-first. A mispredict naming a tag that is already discarded or retired has no effect: no redirect follows and the tail does not move.
- R7: A reused slot retires only after a completion that arrives after its own allocation. An earlier completion aimed at the slot while it was discarded is not remembered.
- R8: A completion with `cmpl_exc`=1 marks its entry as excepting. When that entry is oldest and done, it does not retire. Instead the buffer is emptied, the next allocation reuses the excepting entry's tag, and in the next cycle `redirect_valid` is 1 with `redirect_pc` equal to HANDLER_PC.
- R9: Entries older than an excepting entry retire normally, with no redirect, before the exception is taken.
- R10: When an exception is taken in the same cycle as a mispredict, the exception wins and `redirect_pc` is HANDLER_PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Offer a decoded instruction |
| alloc_areg | input | AREG_W | Architectural destination |
| alloc_old_preg | input | PREG_W | Prior physical mapping of the destination |
| alloc_pc | input | PC_W | Instruction PC |
| alloc_ready | output | 1 | Buffer not full |
| alloc_tag | output | TAG_W | Slot the offered instruction takes |
| cmpl_valid | input | 1 | Completion report |
| cmpl_tag | input | TAG_W | Slot that completed |
| cmpl_exc | input | 1 | Completion raised an exception |
| mp_valid | input | 1 | Branch resolved as mispredicted |
| mp_tag | input | TAG_W | Slot of the mispredicted branch |
| mp_target | input | PC_W | Corrected fetch PC |
| commit_valid | output | 1 | Oldest entry retires this cycle |
| commit_areg | output | AREG_W | Retiring destination |
| commit_old_preg | output | PREG_W | Mapping to return to the free list |
| commit_pc | output | PC_W | Retiring PC |
| redirect_valid | output | 1 | Fetch redirect |
| redirect_pc | output | PC_W | Redirect target |

## Verification
The bench builds the buffer with DEPTH of 8 (3-bit tags) and HANDLER_PC of 0x100. The smaller depth lets a few dozen cycles fill the buffer completely, wrap both pointers past the end, and reuse slots freed by a mispredict. This exposes the full stall, the tag wrap, and the modular age comparison that selects which entries a rollback discards. Out-of-order completions, two branches resolved youngest-first, a stale mispredict and an exception that collides with a mispredict are each driven in their own scenario.

// File: rtl/reorder_buffer.sv
module reorder_buffer #(
  parameter int DEPTH = 16,
  parameter int AREG_W = 5,
  parameter int PREG_W = 7,
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 'h100,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [AREG_W-1:0] alloc_areg,
  input  logic [PREG_W-1:0] alloc_old_preg,
  input  logic [PC_W-1:0]   alloc_pc,
  output logic              alloc_ready,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              cmpl_valid,
  input  logic [TAG_W-1:0]  cmpl_tag,
  input  logic              cmpl_exc,
  input  logic              mp_valid,
  input  logic [TAG_W-1:0]  mp_tag,
  input  logic [PC_W-1:0]   mp_target,
  output logic              commit_valid,
  output logic [AREG_W-1:0] commit_areg,
  output logic [PREG_W-1:0] commit_old_preg,
  output logic [PC_W-1:0]   commit_pc,
  output logic              redirect_valid,
  output logic [PC_W-1:0]   redirect_pc
);
  localparam int PTR_W = TAG_W + 1;

  logic [PTR_W-1:0]  head, tail, count, kill_tail;
  logic [DEPTH-1:0]  vld, vld_n, done, exc, young;
  logic [AREG_W-1:0] areg_q [DEPTH];
  logic [PREG_W-1:0] preg_q [DEPTH];
  logic [PC_W-1:0]   pc_q   [DEPTH];
  logic [TAG_W-1:0]  hidx, tidx, br_off;
  logic              full, flush, retire, kill, accept;

  assign hidx   = head[TAG_W-1:0];
  assign tidx   = tail[TAG_W-1:0];
  assign count  = tail - head;
  assign full   = (count == PTR_W'(DEPTH));
  assign flush  = vld[hidx] & done[hidx] & exc[hidx];
  assign retire = vld[hidx] & done[hidx] & ~exc[hidx];
  assign kill   = ~flush & mp_valid & vld[mp_tag];
  assign accept = alloc_valid & ~full & ~flush & ~kill;
  assign br_off = mp_tag - hidx;
  assign kill_tail = head + PTR_W'(br_off) + PTR_W'(1);

  for (genvar i = 0; i < DEPTH; i++) begin : g_age
    assign young[i] = (TAG_W'(i) - hidx) > br_off;
  end

  always_comb begin
    vld_n = vld;
    if (flush) vld_n = '0;
    else begin
      if (retire) vld_n[hidx] = 1'b0;
      if (kill)   vld_n = vld_n & ~young;
      if (accept) vld_n[tidx] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      vld  <= '0;
      done <= '0;
      exc  <= '0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
    end else begin
      vld <= vld_n;
      redirect_valid <= flush | kill;
      redirect_pc    <= flush ? HANDLER_PC : mp_target;
      if (cmpl_valid && vld[cmpl_tag]) begin
        done[cmpl_tag] <= 1'b1;
        exc[cmpl_tag]  <= cmpl_exc;
      end
      if (accept) begin
        done[tidx] <= 1'b0;
        exc[tidx]  <= 1'b0;
      end
      if (flush) tail <= head;
      else begin
        if (retire) head <= head + PTR_W'(1);
        if (kill)        tail <= kill_tail;
        else if (accept) tail <= tail + PTR_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      areg_q[tidx] <= alloc_areg;
      preg_q[tidx] <= alloc_old_preg;
      pc_q[tidx]   <= alloc_pc;
    end
  end

  assign alloc_ready     = ~full;
  assign alloc_tag       = tidx;
  assign commit_valid    = retire;
  assign commit_areg     = areg_q[hidx];
  assign commit_old_preg = preg_q[hidx];
  assign commit_pc       = pc_q[hidx];
endmodule

// File: rtl/reorder_buffer_chk.sv
module reorder_buffer_chk #(
  parameter int DEPTH = 16,
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 'h100,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int PTR_W = TAG_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PTR_W-1:0] head,
  input logic [PTR_W-1:0] tail,
  input logic             flush,
  input logic             kill,
  input logic [TAG_W-1:0] mp_tag,
  input logic             commit_valid,
  input logic             redirect_valid,
  input logic [PC_W-1:0]  redirect_pc
);
  logic [PTR_W-1:0] occ;
  assign occ = tail - head;

  p_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= PTR_W'(DEPTH));

  p_full_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == PTR_W'(DEPTH) && !flush && !kill) |=> tail == $past(tail));

  p_one_in_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> head == $past(head) + PTR_W'(1));

  p_rollback_r5: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (tail[TAG_W-1:0] == $past(mp_tag) + TAG_W'(1)) && redirect_valid);

  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tail == head) && redirect_valid && redirect_pc == HANDLER_PC);

  p_exc_no_retire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !commit_valid);
endmodule

bind reorder_buffer reorder_buffer_chk #(.DEPTH(DEPTH), .PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) u_chk (
  .clk(clk), .rst_n(rst_n), .head(head), .tail(tail), .flush(flush), .kill(kill),
  .mp_tag(mp_tag), .commit_valid(commit_valid), .redirect_valid(redirect_valid),
  .redirect_pc(redirect_pc)
);

// File: tb/reorder_buffer_tb.sv
`timescale 1ns/1ps
module reorder_buffer_tb;
  localparam int DEPTH = 8;
  localparam int TAG_W = 3;
  localparam logic [31:0] HPC = 32'h100;

  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, alloc_ready, cmpl_valid = 0, cmpl_exc = 0, mp_valid = 0;
  logic [4:0] alloc_areg = 0, commit_areg;
  logic [6:0] alloc_old_preg = 0, commit_old_preg;
  logic [31:0] alloc_pc = 0, mp_target = 0, commit_pc, redirect_pc;
  logic [TAG_W-1:0] alloc_tag, cmpl_tag = 0, mp_tag = 0;
  logic commit_valid, redirect_valid;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  reorder_buffer #(.DEPTH(DEPTH), .HANDLER_PC(HPC)) u_dut (.*);

  task automatic tick; @(posedge clk); #1; endtask

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_alloc(input int n, input logic [TAG_W-1:0] exp_tag, input string req);
    check(alloc_ready == 1, req, alloc_ready, 1);
    check(alloc_tag == exp_tag, req, alloc_tag, exp_tag);
    alloc_valid = 1; alloc_areg = 5'(n); alloc_old_preg = 7'(n + 16); alloc_pc = 32'h1000 + 4 * n;
    tick;
    alloc_valid = 0;
  endtask

  task automatic do_cmpl(input logic [TAG_W-1:0] t, input logic e);
    cmpl_valid = 1; cmpl_tag = t; cmpl_exc = e;
    tick;
    cmpl_valid = 0; cmpl_exc = 0;
  endtask

  task automatic expect_commit(input int n, input string req);
    check(commit_valid == 1, req, commit_valid, 1);
    check(commit_areg == 5'(n) && commit_old_preg == 7'(n + 16), req,
          {commit_areg, commit_old_preg}, {5'(n), 7'(n + 16)});
    check(commit_pc == 32'h1000 + 4 * n, req, commit_pc, 32'h1000 + 4 * n);
    tick;
  endtask

  task automatic expect_idle(input string req);
    check(commit_valid == 0, req, commit_valid, 0);
  endtask

  task automatic do_kill(input logic [TAG_W-1:0] t, input logic [31:0] tgt, input bit with_alloc);
    mp_valid = 1; mp_tag = t; mp_target = tgt;
    if (with_alloc) begin alloc_valid = 1; alloc_areg = 5'd31; alloc_pc = 32'hdead; end
    tick;
    mp_valid = 0; alloc_valid = 0;
  endtask

  task automatic t_reset;
    check(commit_valid == 0, "R1", commit_valid, 0);
    check(redirect_valid == 0, "R1", redirect_valid, 0);
    check(alloc_ready == 1, "R1", alloc_ready, 1);
    check(alloc_tag == 0, "R1", alloc_tag, 0);
  endtask

  task automatic t_inorder;
    do_alloc(1, 0, "R2"); do_alloc(2, 1, "R2"); do_alloc(3, 2, "R2");
    do_cmpl(2, 0);
    expect_idle("R3 head not done");
    do_cmpl(0, 0);
    expect_commit(1, "R3");
    expect_idle("R3 next not done");
    do_cmpl(1, 0);
    expect_commit(2, "R3");
    expect_commit(3, "R3");
    expect_idle("R3 empty");
  endtask

  task automatic t_full;
    for (int k = 0; k < DEPTH; k++) do_alloc(10 + k, TAG_W'(3 + k), "R2 wrap");
    check(alloc_ready == 0, "R4", alloc_ready, 0);
    alloc_valid = 1; alloc_areg = 5'd30; tick; alloc_valid = 0;
    check(alloc_ready == 0, "R4", alloc_ready, 0);
    for (int k = DEPTH - 1; k > 0; k--) do_cmpl(TAG_W'(3 + k), 0);
    expect_idle("R3 oldest pending");
    do_cmpl(3, 0);
    for (int k = 0; k < DEPTH; k++) expect_commit(10 + k, "R3 R4");
    expect_idle("R4 no extra entry");
  endtask

  task automatic t_mispredict;
    for (int k = 0; k < 5; k++) do_alloc(40 + k, TAG_W'(3 + k), "R2");
    do_kill(6, 32'h5000, 1);
    check(redirect_valid == 1, "R5", redirect_valid, 1);
    check(redirect_pc == 32'h5000, "R5", redirect_pc, 32'h5000);
    check(alloc_tag == 7, "R5 rollback", alloc_tag, 7);
    do_kill(4, 32'h6000, 0);
    check(redirect_valid == 1 && redirect_pc == 32'h6000, "R6", redirect_pc, 32'h6000);
    do_kill(6, 32'h7000, 0);
    check(redirect_valid == 0, "R6 stale", redirect_valid, 0);
    check(alloc_tag == 5, "R6 stale", alloc_tag, 5);
    do_cmpl(7, 0);
    do_alloc(50, 5, "R5"); do_alloc(51, 6, "R5"); do_alloc(52, 7, "R7");
    do_cmpl(6, 0); do_cmpl(5, 0); do_cmpl(4, 0); do_cmpl(3, 0);
    expect_commit(40, "R5"); expect_commit(41, "R5");
    expect_commit(50, "R5"); expect_commit(51, "R5");
    expect_idle("R7");
    do_cmpl(7, 0);
    expect_commit(52, "R7");
    expect_idle("R7");
  endtask

  task automatic t_exception;
    do_alloc(60, 0, "R2"); do_alloc(61, 1, "R2"); do_alloc(62, 2, "R2");
    do_cmpl(1, 1);
    do_cmpl(0, 0);
    check(redirect_valid == 0, "R9", redirect_valid, 0);
    expect_commit(60, "R9");
    expect_idle("R8 no retire");
    do_kill(2, 32'h9000, 0);
    check(redirect_valid == 1, "R8", redirect_valid, 1);
    check(redirect_pc == HPC, "R10", redirect_pc, HPC);
    expect_idle("R8 emptied");
    check(alloc_tag == 1, "R8", alloc_tag, 1);
    tick;
    check(redirect_valid == 0, "R8", redirect_valid, 0);
    do_alloc(63, 1, "R8");
    do_cmpl(1, 0);
    expect_commit(63, "R8");
    expect_idle("R8");
  endtask

  initial begin
    repeat (3) tick;
    rst_n = 1;
    tick;
    t_reset;
    t_inorder;
    t_full;
    t_mispredict;
    t_exception;
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule